// File: doc/BRIEF.md
# Host-Side Byte Queues with Ready Pins

This block holds the data path between a host (or a block-transfer engine) and one serial channel. A transmit queue takes bytes written by the host and hands them to a transmitter through a pop port. A receive queue takes bytes pushed by a receiver and hands them to the host through a read strobe. Both read ports are show-ahead: the byte at the head of a queue is always visible on its data output.

Two active-low ready pins, `rxrdy_n` and `txrdy_n`, tell the host when to move data. Three rules drive them. With the queues switched off, each direction holds a single byte. With the queues on and block mode off, the pins work byte by byte. With block mode on, the receive pin asserts at a programmable fill threshold or on a timeout, then stays asserted until the queue drains. In the same mode the transmit pin stays asserted until the queue is full.

The block also reports fill levels, empty and full flags, and a one-cycle overrun pulse per direction. Serial shifting, baud generation, interrupts and flow control are outside this block.

Top module: `uart_rdy_fifo`

## Requirements
- R1: Each queue holds up to DEPTH bytes (default 128) and returns them in the order they arrived. `*_level` gives the byte count, `*_empty` is high at count 0, and `*_full` is high at capacity. A level change appears in the cycle after the strobe that causes it.
- R2: While `fifo_en` is 0, each queue holds at most one byte, so its full flag rises as soon as it holds one byte.
- R3: Any change of `fifo_en` empties both queues by the following cycle. Data offered in the cycle of the change is discarded. With both queues empty, `rxrdy_n` is 1 and `txrdy_n` is 0.
- R4: While block mode is not in effect, `rxrdy_n` is 0 exactly when the receive queue holds at least one byte.
- R5: While block mode is not in effect, `txrdy_n` is 0 exactly when the transmit queue is empty.
- R6: In block mode (`fifo_en`=1 and `blk_mode`=1), `rxrdy_n` goes to 0 in the first cycle in which `rx_level` is at or above the trigger level `rx_trig`.
- R7: A `rx_trig` value of 0 acts as a trigger level of 1.
- R8: In block mode, an `rx_tmo` pulse drives `rxrdy_n` to 0 in the same cycle if the receive queue is not empty. A pulse while the queue is empty has no effect, either in that cycle or later.
- R9: In block mode, once `rxrdy_n` is 0 it stays 0 even when the level falls below the trigger. It returns to 1 in the cycle the receive queue becomes empty.
- R10: In block mode, `txrdy_n` is 1 only while the transmit queue is full.
- R11: A host write into a full transmit queue, or a receiver push into a full receive queue, is dropped and leaves the contents unchanged. The matching overrun output is 1 for the following cycle only.
- R12: `blk_mode` has no effect while `fifo_en` is 0.
- R13: A host read or transmitter pop on an empty queue is ignored, and the level stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en | input | 1 | Queue enable (0 = one holding byte per direction) |
| blk_mode | input | 1 | Block-transfer pin rules, valid only with fifo_en=1 |
| rx_trig | input | TW (7) | Receive trigger level, 0 acts as 1 |
| rx_tmo | input | 1 | One-cycle receive timeout pulse |
| host_wr | input | 1 | Host write strobe into the transmit queue |
| host_wdata | input | 8 | Host write byte |
| host_rd | input | 1 | Host read strobe from the receive queue |
| host_rdata | output | 8 | Head byte of the receive queue |
| rx_push | input | 1 | Receiver push strobe |
| rx_pdata | input | 8 | Receiver byte |
| tx_pop | input | 1 | Transmitter pop strobe |
| tx_pdata | output | 8 | Head byte of the transmit queue |
| rxrdy_n | output | 1 | Receive ready pin, active low |
| txrdy_n | output | 1 | Transmit ready pin, active low |
| rx_level | output | LW (8) | Receive byte count |
| tx_level | output | LW (8) | Transmit byte count |
| rx_empty | output | 1 | Receive queue empty |
| rx_full | output | 1 | Receive queue full |
| tx_empty | output | 1 | Transmit queue empty |
| tx_full | output | 1 | Transmit queue full |
| rx_ovr | output | 1 | Receive push dropped in the previous cycle |
| tx_ovr | output | 1 | Transmit write dropped in the previous cycle |

## Verification
The bench builds the block with DEPTH=8, which gives a 3-bit trigger field. At that size every trigger value from 0 to 7 can be swept, and for each one the receive queue is filled from empty to full and then drained back to empty. The pin level is checked against the arithmetic expectation at every single count. The small depth also puts both full boundaries, the overruns, and every mode change with data in flight within a few cycles of each other.

// File: rtl/uart_rdy_pkg.sv
package uart_rdy_pkg;

  typedef enum logic [1:0] {
    PIN_SINGLE = 2'd0,
    PIN_CHAR   = 2'd1,
    PIN_BLOCK  = 2'd2
  } pin_mode_e;

  function automatic pin_mode_e pin_mode(input logic en, input logic blk);
    if (!en)     return PIN_SINGLE;
    else if (blk) return PIN_BLOCK;
    else          return PIN_CHAR;
  endfunction

endpackage

// File: rtl/urf_fifo.sv
module urf_fifo #(
  parameter int DEPTH = 128,
  parameter int DW    = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          cap_one,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output logic [LW-1:0] level,
  output logic          empty,
  output logic          full,
  output logic          ovr
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr_q, wr_ptr_d, wr_inc;
  logic [AW-1:0] rd_ptr_q, rd_ptr_d, rd_inc;
  logic [LW-1:0] level_q, level_d;
  logic          ovr_q, ovr_d;
  logic          do_push, do_pop;

  generate
    if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
      assign wr_inc = wr_ptr_q + 1'b1;
      assign rd_inc = rd_ptr_q + 1'b1;
    end else begin : g_wrap
      assign wr_inc = (wr_ptr_q == AW'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
      assign rd_inc = (rd_ptr_q == AW'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
    end
  endgenerate

  assign empty   = (level_q == '0);
  assign full    = cap_one ? !empty : (level_q == LW'(DEPTH));
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    level_d  = level_q;
    ovr_d    = push && full && !flush;
    if (flush) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      level_d  = '0;
    end else begin
      if (do_push) wr_ptr_d = wr_inc;
      if (do_pop)  rd_ptr_d = rd_inc;
      level_d = level_q + LW'(do_push) - LW'(do_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level_q  <= '0;
      ovr_q    <= 1'b0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      level_q  <= level_d;
      ovr_q    <= ovr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr_q] <= wdata;
  end

  assign rdata = mem[rd_ptr_q];
  assign level = level_q;
  assign ovr   = ovr_q;

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH)); // R1
  AST_SINGLE_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    cap_one |=> (!cap_one || level <= LW'(1))); // R2
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty); // R3
  AST_OVR_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop && !flush) |=> (ovr && level == $past(level))); // R11
  AST_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push) |=> empty); // R13

endmodule

// File: rtl/urf_pin_ctl.sv
module urf_pin_ctl
  import uart_rdy_pkg::*;
#(
  parameter int LW = 8,
  parameter int TW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_en,
  input  logic          blk_mode,
  input  logic [TW-1:0] rx_trig,
  input  logic          rx_tmo,
  input  logic [LW-1:0] rx_level,
  input  logic          rx_empty,
  input  logic          tx_empty,
  input  logic          tx_full,
  output logic          rxrdy_n,
  output logic          txrdy_n
);

  pin_mode_e     mode;
  logic [TW-1:0] trig_eff;
  logic          at_trig;
  logic          blk_rx_go;
  logic          hold_q, hold_d;

  assign mode      = pin_mode(fifo_en, blk_mode);
  assign trig_eff  = (rx_trig == '0) ? TW'(1) : rx_trig;
  assign at_trig   = (rx_level >= LW'(trig_eff));
  assign blk_rx_go = !rx_empty && (hold_q || at_trig || rx_tmo);

  always_comb begin
    hold_d = (mode == PIN_BLOCK) && blk_rx_go;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= 1'b0;
    else        hold_q <= hold_d;
  end

  always_comb begin
    unique case (mode)
      PIN_BLOCK: begin
        rxrdy_n = !blk_rx_go;
        txrdy_n = tx_full;
      end
      default: begin
        rxrdy_n = rx_empty;
        txrdy_n = !tx_empty;
      end
    endcase
  end

  AST_RX_EMPTY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    rx_empty |-> rxrdy_n); // R9
  AST_BLK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PIN_BLOCK && !rxrdy_n) |=> (mode != PIN_BLOCK || rx_empty || !rxrdy_n)); // R9
  AST_TMO_ASSERT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PIN_BLOCK && rx_tmo && !rx_empty) |-> !rxrdy_n); // R8
  AST_BLK_TX_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PIN_BLOCK && !tx_full) |-> !txrdy_n); // R10
  AST_CHAR_TX_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != PIN_BLOCK && tx_empty) |-> !txrdy_n); // R5

endmodule

// File: rtl/uart_rdy_fifo.sv
module uart_rdy_fifo #(
  parameter int DEPTH = 128,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW   = AW + 1,
  localparam int TW   = AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_en,
  input  logic          blk_mode,
  input  logic [TW-1:0] rx_trig,
  input  logic          rx_tmo,
  input  logic          host_wr,
  input  logic [7:0]    host_wdata,
  input  logic          host_rd,
  output logic [7:0]    host_rdata,
  input  logic          rx_push,
  input  logic [7:0]    rx_pdata,
  input  logic          tx_pop,
  output logic [7:0]    tx_pdata,
  output logic          rxrdy_n,
  output logic          txrdy_n,
  output logic [LW-1:0] rx_level,
  output logic [LW-1:0] tx_level,
  output logic          rx_empty,
  output logic          rx_full,
  output logic          tx_empty,
  output logic          tx_full,
  output logic          rx_ovr,
  output logic          tx_ovr
);

  logic en_q;
  logic flush;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= fifo_en;
  end

  assign flush = fifo_en ^ en_q;

  urf_fifo #(.DEPTH(DEPTH), .DW(8)) u_rxq (
    .clk    (clk),
    .rst_n  (rst_n),
    .flush  (flush),
    .cap_one(!fifo_en),
    .push   (rx_push),
    .wdata  (rx_pdata),
    .pop    (host_rd),
    .rdata  (host_rdata),
    .level  (rx_level),
    .empty  (rx_empty),
    .full   (rx_full),
    .ovr    (rx_ovr)
  );

  urf_fifo #(.DEPTH(DEPTH), .DW(8)) u_txq (
    .clk    (clk),
    .rst_n  (rst_n),
    .flush  (flush),
    .cap_one(!fifo_en),
    .push   (host_wr),
    .wdata  (host_wdata),
    .pop    (tx_pop),
    .rdata  (tx_pdata),
    .level  (tx_level),
    .empty  (tx_empty),
    .full   (tx_full),
    .ovr    (tx_ovr)
  );

  urf_pin_ctl #(.LW(LW), .TW(TW)) u_pins (
    .clk     (clk),
    .rst_n   (rst_n),
    .fifo_en (fifo_en),
    .blk_mode(blk_mode),
    .rx_trig (rx_trig),
    .rx_tmo  (rx_tmo),
    .rx_level(rx_level),
    .rx_empty(rx_empty),
    .tx_empty(tx_empty),
    .tx_full (tx_full),
    .rxrdy_n (rxrdy_n),
    .txrdy_n (txrdy_n)
  );

  AST_BLK_IGNORED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_en) |-> (rxrdy_n == rx_empty && txrdy_n == !tx_empty)); // R12

endmodule

// File: tb/tb_uart_rdy_fifo.sv
module tb_uart_rdy_fifo;

  localparam int D  = 8;
  localparam int AW = 3;
  localparam int LW = AW + 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          fifo_en, blk_mode, rx_tmo;
  logic [AW-1:0] rx_trig;
  logic          host_wr, host_rd, rx_push, tx_pop;
  logic [7:0]    host_wdata, rx_pdata, host_rdata, tx_pdata;
  logic          rxrdy_n, txrdy_n, rx_empty, rx_full, tx_empty, tx_full, rx_ovr, tx_ovr;
  logic [LW-1:0] rx_level, tx_level;

  int n_chk  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  uart_rdy_fifo #(.DEPTH(D)) dut (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .blk_mode(blk_mode),
    .rx_trig(rx_trig), .rx_tmo(rx_tmo), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rd(host_rd), .host_rdata(host_rdata), .rx_push(rx_push), .rx_pdata(rx_pdata),
    .tx_pop(tx_pop), .tx_pdata(tx_pdata), .rxrdy_n(rxrdy_n), .txrdy_n(txrdy_n),
    .rx_level(rx_level), .tx_level(tx_level), .rx_empty(rx_empty), .rx_full(rx_full),
    .tx_empty(tx_empty), .tx_full(tx_full), .rx_ovr(rx_ovr), .tx_ovr(tx_ovr)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clk1();
    @(posedge clk);
    #1;
    host_wr = 1'b0; host_rd = 1'b0; rx_push = 1'b0; tx_pop = 1'b0; rx_tmo = 1'b0;
  endtask

  function automatic logic [7:0] pat(input int s, input int i);
    return 8'((s * 37 + i * 11 + 5) & 255);
  endfunction

  task automatic rx_in(input logic [7:0] b);
    rx_push = 1'b1; rx_pdata = b; clk1();
  endtask

  task automatic tx_in(input logic [7:0] b);
    host_wr = 1'b1; host_wdata = b; clk1();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; fifo_en = 1'b0; blk_mode = 1'b0; rx_trig = '0; rx_tmo = 1'b0;
    host_wr = 1'b0; host_rd = 1'b0; rx_push = 1'b0; tx_pop = 1'b0;
    host_wdata = '0; rx_pdata = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
    chk("R3 reset rxrdy_n", int'(rxrdy_n), 1);
    chk("R3 reset txrdy_n", int'(txrdy_n), 0);
    chk("R1 reset rx_level", int'(rx_level), 0);
    chk("R1 reset tx_empty", int'(tx_empty), 1);

    // Single holding byte, blk_mode both ways (R2 R4 R5 R11 R12)
    for (int b = 0; b < 2; b++) begin
      blk_mode = 1'(b);
      clk1();
      chk("R4 R12 idle rxrdy_n", int'(rxrdy_n), 1);
      rx_in(pat(b, 0));
      chk("R2 rx_level one", int'(rx_level), 1);
      chk("R2 rx_full at one", int'(rx_full), 1);
      chk("R4 R12 rxrdy_n held byte", int'(rxrdy_n), 0);
      rx_in(pat(b, 1));
      chk("R11 rx_ovr pulse", int'(rx_ovr), 1);
      chk("R11 rx_level kept", int'(rx_level), 1);
      clk1();
      chk("R11 rx_ovr one cycle", int'(rx_ovr), 0);
      chk("R11 rx byte kept", int'(host_rdata), int'(pat(b, 0)));
      host_rd = 1'b1; clk1();
      chk("R4 rxrdy_n after read", int'(rxrdy_n), 1);
      chk("R5 R12 txrdy_n empty", int'(txrdy_n), 0);
      tx_in(pat(b, 2));
      chk("R5 R12 txrdy_n byte", int'(txrdy_n), 1);
      chk("R2 tx_full at one", int'(tx_full), 1);
      tx_in(pat(b, 3));
      chk("R11 tx_ovr pulse", int'(tx_ovr), 1);
      chk("R11 tx byte kept", int'(tx_pdata), int'(pat(b, 2)));
      tx_pop = 1'b1; clk1();
      chk("R5 txrdy_n after pop", int'(txrdy_n), 0);
    end

    // Enable with data present -> flush (R3)
    blk_mode = 1'b0;
    rx_in(8'h11);
    tx_in(8'h22);
    fifo_en = 1'b1;
    clk1();
    chk("R3 flush rx_level", int'(rx_level), 0);
    chk("R3 flush tx_level", int'(tx_level), 0);
    chk("R3 flush rxrdy_n", int'(rxrdy_n), 1);
    chk("R3 flush txrdy_n", int'(txrdy_n), 0);

    // Character mode: full sweep of both queues (R1 R4 R5 R11)
    for (int i = 0; i < D; i++) begin
      rx_in(pat(3, i));
      chk("R1 rx_level fill", int'(rx_level), i + 1);
      chk("R4 rxrdy_n fill", int'(rxrdy_n), 0);
      chk("R1 rx_full fill", int'(rx_full), (i == D - 1) ? 1 : 0);
    end
    rx_in(8'hEE);
    chk("R11 rx_ovr deep", int'(rx_ovr), 1);
    chk("R11 rx_level deep", int'(rx_level), D);
    for (int i = 0; i < D; i++) begin
      chk("R1 rx order", int'(host_rdata), int'(pat(3, i)));
      host_rd = 1'b1; clk1();
      chk("R4 rxrdy_n drain", int'(rxrdy_n), (i == D - 1) ? 1 : 0);
    end
    for (int i = 0; i < D; i++) begin
      tx_in(pat(4, i));
      chk("R5 txrdy_n fill", int'(txrdy_n), 1);
      chk("R1 tx_level fill", int'(tx_level), i + 1);
    end
    tx_in(8'hEE);
    chk("R11 tx_ovr deep", int'(tx_ovr), 1);
    for (int i = 0; i < D; i++) begin
      chk("R1 tx order", int'(tx_pdata), int'(pat(4, i)));
      tx_pop = 1'b1; clk1();
      chk("R5 txrdy_n drain", int'(txrdy_n), (i == D - 1) ? 0 : 1);
    end

    // Reads and pops on empty (R13)
    host_rd = 1'b1; tx_pop = 1'b1; clk1();
    chk("R13 rx_level empty read", int'(rx_level), 0);
    chk("R13 tx_level empty pop", int'(tx_level), 0);
    rx_in(8'h3C);
    chk("R13 rx after empty read", int'(host_rdata), 8'h3C);
    host_rd = 1'b1; clk1();

    // Block mode trigger sweep (R6 R7 R9)
    blk_mode = 1'b1;
    for (int t = 0; t < D; t++) begin
      int eff;
      rx_trig = AW'(t);
      eff = (t == 0) ? 1 : t;
      clk1();
      chk("R9 block idle rxrdy_n", int'(rxrdy_n), 1);
      for (int i = 1; i <= D; i++) begin
        rx_in(pat(t, i));
        chk((t == 0) ? "R7 trig zero" : "R6 trigger", int'(rxrdy_n), (i >= eff) ? 0 : 1);
      end
      for (int i = D; i >= 1; i--) begin
        chk("R1 block order", int'(host_rdata), int'(pat(t, D - i + 1)));
        host_rd = 1'b1; clk1();
        chk("R9 hold until empty", int'(rxrdy_n), (i - 1 > 0) ? 0 : 1);
      end
    end

    // Timeout (R8 R9)
    rx_trig = AW'(D - 1);
    rx_in(8'h01);
    rx_in(8'h02);
    chk("R6 below trigger", int'(rxrdy_n), 1);
    rx_tmo = 1'b1; #1;
    chk("R8 tmo asserts", int'(rxrdy_n), 0);
    clk1();
    chk("R9 tmo held", int'(rxrdy_n), 0);
    host_rd = 1'b1; clk1();
    chk("R9 tmo held one left", int'(rxrdy_n), 0);
    host_rd = 1'b1; clk1();
    chk("R9 release at empty", int'(rxrdy_n), 1);
    rx_tmo = 1'b1; #1;
    chk("R8 tmo on empty", int'(rxrdy_n), 1);
    clk1();
    rx_in(8'h03);
    chk("R8 tmo on empty no memory", int'(rxrdy_n), 1);
    host_rd = 1'b1; clk1();

    // Block transmit (R10 R11)
    for (int i = 1; i <= D; i++) begin
      tx_in(pat(6, i));
      chk("R10 txrdy_n fill", int'(txrdy_n), (i == D) ? 1 : 0);
    end
    tx_in(8'hEE);
    chk("R11 tx_ovr block", int'(tx_ovr), 1);
    chk("R10 txrdy_n full", int'(txrdy_n), 1);
    tx_pop = 1'b1; clk1();
    chk("R10 txrdy_n room", int'(txrdy_n), 0);

    // Disable with held pin and data (R3)
    rx_trig = AW'(2);
    rx_in(8'h0A);
    rx_in(8'h0B);
    chk("R6 trig two", int'(rxrdy_n), 0);
    fifo_en = 1'b0;
    clk1();
    chk("R3 disable rx_level", int'(rx_level), 0);
    chk("R3 disable tx_level", int'(tx_level), 0);
    chk("R3 disable rxrdy_n", int'(rxrdy_n), 1);
    chk("R3 disable txrdy_n", int'(txrdy_n), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule